// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive monitor for an asynchronous DRAM control bus with one row strobe, two byte-lane column strobes, a write enable and an output enable, all active low and already sampled into the monitor's clock domain. It watches each row-strobe low period and, when the row strobe returns high, reports which kind of memory cycle took place, how many column accesses were made inside the period, and whether any protocol rule was broken.

The two column strobes are merged into one combined strobe that is active while either lane is low, so an access opens on the earlier lane fall and closes on the later lane rise. The write-enable and output-enable history inside each access separates reads, early writes, delayed writes and read-modify-write accesses. Periods with no column access are row-only refreshes. Periods entered with a column strobe already low are column-before-row refreshes, and these become self-refresh once the row strobe has stayed low long enough. The monitor is intended for a simulation environment or as an on-chip protocol checker. It sees only what the sampling clock resolves.

Top module: `dram_cycle_monitor`

## Requirements
- R1: An access opens on the first sample with either column strobe low and closes on the first sample with both high. Lane strobes that are staggered inside that window count as one access.
- R2: If either column strobe is low on the sample where the row strobe is first seen low, the period is reported as code 6 (column-before-row refresh) with an access count of 0. One lane low is enough.
- R3: A period with no column strobe low at any point is reported as code 5 (row-only refresh) with an access count of 0.
- R4: If write enable is low on the sample where an access opens, that access is an early write, code 2.
- R5: If write enable is first seen low after the opening sample and output enable was not low earlier in the access, the access is a delayed write, code 3.
- R6: If output enable was low on a sample strictly before the first low sample of write enable, with write enable high on that sample, the access is a read-modify-write, code 4.
- R7: An access during which write enable stays high is a read, code 1.
- R8: A column-before-row refresh period whose row strobe stayed low for at least SELF_REF_CYCLES samples is reported as code 7 (self-refresh) and never carries the overlong flag.
- R9: The lane flag is set when, within one access, both byte lanes fell and write enable was low at one lane's fall but high at the other's.
- R10: The access count equals the number of accesses that closed in the period, and counts that close when the row strobe rises also included. The page flag is 1 when that count is 2 or more. The reported code of an access period is the code of its first access.
- R11: The overlong flag is set when the row strobe stayed low for more than RAS_MAX_CYCLES samples, unless the period is reported as self-refresh.
- R12: The report pulse is high for exactly one clock: the clock after the edge whose sample first shows the row strobe high again. After reset the pulse is low and all report fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte-lane column strobe, active low |
| lcas_n | input | 1 | Lower byte-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rep_valid | output | 1 | One-clock report pulse at the end of a period |
| rep_kind | output | 3 | Cycle code: 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 self-refresh |
| rep_page | output | 1 | Period held two or more accesses |
| rep_count | output | ACC_W | Number of accesses in the period (saturating) |
| rep_lane_err | output | 1 | Byte lanes used different write timing within one access |
| rep_long_err | output | 1 | Row strobe was low beyond the programmed maximum |

## Verification
The assertions assume the strobes are clean sampled levels. They also assume the monitor leaves reset with the row strobe high, so that every report closes a period the block saw open. The stimulus raises and lowers the row strobe only on whole clock periods, and it keeps it high for at least two clocks between periods so that no report pulse can be repeated. Write enable and output enable change only while an access is open, and never on the sample where it closes. Random accesses use matching timing on both lanes, and only the directed lane cases break that rule.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_DWR   = 3'd3,
    K_RMW   = 3'd4,
    K_RONLY = 3'd5,
    K_CBR   = 3'd6,
    K_SELF  = 3'd7
  } kind_e;

  // Resolve an access from its write-enable and output-enable history.
  function automatic kind_e access_kind(logic early, logic we_late, logic oe_first);
    if (early)        return K_EWR;
    else if (we_late) return oe_first ? K_RMW : K_DWR;
    else              return K_READ;
  endfunction
endpackage

// File: rtl/dcm_lane_track.sv
module dcm_lane_track (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  input  logic arm,
  input  logic we_n,
  input  logic clear,
  output logic seen,
  output logic early
);
  logic strobe_q;
  logic fall;

  assign fall = strobe_q & ~strobe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;
      seen     <= 1'b0;
      early    <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      if (clear) begin
        seen  <= 1'b0;
        early <= 1'b0;
      end else if (fall && arm && !seen) begin
        seen  <= 1'b1;
        early <= ~we_n;
      end
    end
  end

  AST_LANE_CLEARED: assert property (@(posedge clk) disable iff (rst) clear |=> !seen); // R9
endmodule

// File: rtl/dcm_access_track.sv
module dcm_access_track
  import dcm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cas_act,
  input  logic  we_n,
  input  logic  oe_n,
  input  logic  arm,
  input  logic  force_end,
  output logic  acc_end,
  output kind_e acc_kind
);
  logic cas_q;
  logic in_acc;
  logic acc_early;
  logic acc_we_late;
  logic acc_oe_first;
  logic start;

  assign start    = cas_act & ~cas_q & arm;
  assign acc_end  = in_acc & (~cas_act | force_end);
  assign acc_kind = access_kind(acc_early, acc_we_late, acc_oe_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_q        <= 1'b0;
      in_acc       <= 1'b0;
      acc_early    <= 1'b0;
      acc_we_late  <= 1'b0;
      acc_oe_first <= 1'b0;
    end else begin
      cas_q <= cas_act;
      if (start) begin
        in_acc       <= 1'b1;
        acc_early    <= ~we_n;
        acc_we_late  <= 1'b0;
        acc_oe_first <= ~oe_n & we_n;
      end else if (acc_end) begin
        in_acc <= 1'b0;
      end else if (in_acc && !acc_early && !acc_we_late) begin
        if (!oe_n && we_n) acc_oe_first <= 1'b1;
        if (!we_n)         acc_we_late  <= 1'b1;
      end
    end
  end

  AST_ACC_CLOSES: assert property (@(posedge clk) disable iff (rst) acc_end |=> !in_acc); // R1
  AST_EARLY_STABLE: assert property (@(posedge clk) disable iff (rst)
    (in_acc && $past(in_acc)) |-> $stable(acc_early)); // R4
endmodule

// File: rtl/dcm_ras_timer.sv
module dcm_ras_timer #(
  parameter int SELF_REF_CYCLES = 5000,
  parameter int RAS_MAX_CYCLES  = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  input  logic ras_fall,
  output logic too_long,
  output logic self_ok
);
  localparam int CNT_W = $clog2(SELF_REF_CYCLES + 1);
  localparam logic [CNT_W-1:0] SELF_L = CNT_W'(SELF_REF_CYCLES);
  localparam logic [CNT_W-1:0] MAX_L  = CNT_W'(RAS_MAX_CYCLES);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (ras_fall) begin
      low_cnt <= CNT_W'(1);
    end else if (!ras_n && low_cnt != '0 && low_cnt < SELF_L) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign too_long = low_cnt > MAX_L;
  assign self_ok  = low_cnt >= SELF_L;

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst) low_cnt <= SELF_L); // R8
  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ras_n && !ras_fall) |=> $stable(low_cnt)); // R11
endmodule

// File: rtl/dram_cycle_monitor.sv
module dram_cycle_monitor
  import dcm_pkg::*;
#(
  parameter int SELF_REF_CYCLES = 5000,
  parameter int RAS_MAX_CYCLES  = 500,
  parameter int ACC_W           = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             ucas_n,
  input  logic             lcas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             rep_valid,
  output logic [2:0]       rep_kind,
  output logic             rep_page,
  output logic [ACC_W-1:0] rep_count,
  output logic             rep_lane_err,
  output logic             rep_long_err
);
  localparam int LANES = 2;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic             ras_q;
  logic             in_per;
  logic             norm;
  kind_e            first_kind;
  logic [ACC_W-1:0] acc_cnt;
  logic             lane_err_r;

  logic             cas_act;
  logic             ras_fall;
  logic             ras_rise;
  logic             arm;
  logic             acc_end;
  kind_e            acc_kind;
  logic             too_long;
  logic             self_ok;
  logic [LANES-1:0] lane_n;
  logic [LANES-1:0] lane_seen;
  logic [LANES-1:0] lane_early;
  logic             mism;
  logic [ACC_W-1:0] cnt_next;
  kind_e            first_next;
  kind_e            per_kind;

  assign cas_act  = ~(ucas_n & lcas_n);
  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n & in_per;
  assign arm      = in_per & norm & ~ras_n & ~ras_fall;
  assign lane_n   = {ucas_n, lcas_n};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dcm_lane_track u_lane (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (lane_n[g]),
      .arm      (arm),
      .we_n     (we_n),
      .clear    (acc_end | ras_fall),
      .seen     (lane_seen[g]),
      .early    (lane_early[g])
    );
  end

  dcm_access_track u_acc (
    .clk       (clk),
    .rst       (rst),
    .cas_act   (cas_act),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .arm       (arm),
    .force_end (ras_rise),
    .acc_end   (acc_end),
    .acc_kind  (acc_kind)
  );

  dcm_ras_timer #(
    .SELF_REF_CYCLES (SELF_REF_CYCLES),
    .RAS_MAX_CYCLES  (RAS_MAX_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .ras_fall (ras_fall),
    .too_long (too_long),
    .self_ok  (self_ok)
  );

  assign mism       = acc_end & (&lane_seen) & (lane_early[0] ^ lane_early[1]);
  assign cnt_next   = (acc_end && acc_cnt != ACC_MAX) ? acc_cnt + 1'b1 : acc_cnt;
  assign first_next = (acc_end && acc_cnt == '0) ? acc_kind : first_kind;

  always_comb begin
    if (!norm)               per_kind = self_ok ? K_SELF : K_CBR;
    else if (cnt_next == '0) per_kind = K_RONLY;
    else                     per_kind = first_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q      <= 1'b1;
      in_per     <= 1'b0;
      norm       <= 1'b0;
      first_kind <= K_NONE;
      acc_cnt    <= '0;
      lane_err_r <= 1'b0;
    end else begin
      ras_q <= ras_n;
      if (ras_fall) begin
        in_per     <= 1'b1;
        norm       <= ~cas_act;
        first_kind <= K_NONE;
        acc_cnt    <= '0;
        lane_err_r <= 1'b0;
      end else begin
        if (ras_rise) in_per <= 1'b0;
        acc_cnt    <= cnt_next;
        first_kind <= first_next;
        if (mism) lane_err_r <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_valid    <= 1'b0;
      rep_kind     <= 3'd0;
      rep_page     <= 1'b0;
      rep_count    <= '0;
      rep_lane_err <= 1'b0;
      rep_long_err <= 1'b0;
    end else begin
      rep_valid <= ras_rise;
      if (ras_rise) begin
        rep_kind     <= per_kind;
        rep_page     <= cnt_next >= ACC_W'(2);
        rep_count    <= cnt_next;
        rep_lane_err <= lane_err_r | mism;
        rep_long_err <= too_long & ~(~norm & self_ok);
      end
    end
  end

  AST_ONE_CLOCK_REPORT: assert property (@(posedge clk) disable iff (rst)
    rep_valid |=> !rep_valid); // R12
  AST_REFRESH_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_kind >= 3'd5) |-> rep_count == '0); // R3
  AST_ACCESS_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_kind != 3'd0 && rep_kind < 3'd5) |-> rep_count != '0); // R10
  AST_SELF_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_kind == 3'd7) |-> !rep_long_err); // R8
  AST_CBR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (in_per && !norm) |-> acc_cnt == '0); // R2
endmodule

// File: tb/dram_cycle_monitor_tb.sv
module dram_cycle_monitor_tb;
  localparam int SELF = 200;
  localparam int RMAX = 60;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic rep_valid, rep_page, rep_lane_err, rep_long_err;
  logic [2:0] rep_kind;
  logic [AW-1:0] rep_count;

  int checks = 0;
  int fails = 0;
  int low_run = 0;
  logic run_active = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cycle_monitor #(.SELF_REF_CYCLES(SELF), .RAS_MAX_CYCLES(RMAX), .ACC_W(AW)) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .rep_valid(rep_valid), .rep_kind(rep_kind),
    .rep_page(rep_page), .rep_count(rep_count), .rep_lane_err(rep_lane_err),
    .rep_long_err(rep_long_err));

  // Bench-side count of row-strobe low samples.
  always @(posedge clk) begin
    if (!ras_n) low_run <= run_active ? low_run + 1 : 1;
    run_active <= ~ras_n;
  end

  function automatic int code_of(int t);
    case (t)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // t: 0 read, 1 early write, 2 delayed write, 3 read-modify-write
  task automatic do_access(int t, logic [1:0] mask);
    @(negedge clk);
    lcas_n = ~mask[0];
    ucas_n = ~mask[1];
    if (t == 0 || t == 3) oe_n = 1'b0;
    if (t == 1) we_n = 1'b0;
    @(negedge clk);
    if (t == 2) we_n = 1'b0;
    if (t == 3) begin oe_n = 1'b1; we_n = 1'b0; end
    @(negedge clk);
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic end_and_check(string req, int kind, int cnt, int lane, int lng);
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    chk({req, " valid"}, int'(rep_valid), 1);
    chk({req, " kind"}, int'(rep_kind), kind);
    chk({req, " count"}, int'(rep_count), cnt);
    chk({req, " page"}, int'(rep_page), (cnt >= 2) ? 1 : 0);
    chk({req, " lane"}, int'(rep_lane_err), lane);
    chk({req, " long"}, int'(rep_long_err), lng);
    @(negedge clk);
    chk("R12 pulse one clock", int'(rep_valid), 0);
  endtask

  task automatic hold_low(int n);
    @(negedge clk);
    ras_n = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset valid", int'(rep_valid), 0);
    chk("R12 reset kind", int'(rep_kind), 0);
    chk("R12 reset count", int'(rep_count), 0);

    // R3 row-only refresh, both sides of the maximum (R11)
    hold_low(RMAX);
    end_and_check("R3 R11 row-only at max", 5, 0, 0, 0);
    hold_low(RMAX + 1);
    end_and_check("R3 R11 row-only over max", 5, 0, 0, 1);

    // R7 R4 R5 R6 single accesses
    @(negedge clk); ras_n = 1'b0; do_access(0, 2'b11);
    end_and_check("R7 read", 1, 1, 0, 0);
    @(negedge clk); ras_n = 1'b0; do_access(1, 2'b01);
    end_and_check("R4 early write", 2, 1, 0, 0);
    @(negedge clk); ras_n = 1'b0; do_access(2, 2'b10);
    end_and_check("R5 delayed write", 3, 1, 0, 0);
    @(negedge clk); ras_n = 1'b0; do_access(3, 2'b11);
    end_and_check("R6 read-modify-write", 4, 1, 0, 0);

    // R1 staggered lanes form one access
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); lcas_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); ucas_n = 1'b0;
    @(negedge clk); lcas_n = 1'b1;
    @(negedge clk); ucas_n = 1'b1; oe_n = 1'b1;
    end_and_check("R1 staggered lanes", 1, 1, 0, 0);

    // R9 lanes with different write timing
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); lcas_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); ucas_n = 1'b0;
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1;
    end_and_check("R9 lane mismatch", 3, 1, 1, 0);

    // R10 access closed by the row strobe rising
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    end_and_check("R10 access closed by row rise", 1, 1, 0, 0);
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R2 one lane low before the row strobe
    @(negedge clk); ucas_n = 1'b0;
    hold_low(5);
    end_and_check("R2 refresh one lane", 6, 0, 0, 0);
    @(negedge clk); ucas_n = 1'b1;

    // R8 self-refresh threshold
    @(negedge clk); lcas_n = 1'b0; ucas_n = 1'b0;
    hold_low(SELF);
    end_and_check("R8 self-refresh at threshold", 7, 0, 0, 0);
    hold_low(SELF - 1);
    end_and_check("R8 R11 refresh below threshold", 6, 0, 0, 1);
    @(negedge clk); lcas_n = 1'b1; ucas_n = 1'b1;
    @(negedge clk);

    // R10 random page-mode periods
    for (int p = 0; p < 60; p++) begin
      int n;
      int first_t;
      n = $urandom_range(0, 5);
      first_t = 0;
      @(negedge clk); ras_n = 1'b0;
      for (int a = 0; a < n; a++) begin
        int t;
        logic [1:0] m;
        t = $urandom_range(0, 3);
        m = 2'($urandom_range(1, 3));
        if (a == 0) first_t = t;
        do_access(t, m);
      end
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(10, 40)) @(negedge clk);
      @(negedge clk);
      ras_n = 1'b1;
      @(negedge clk);
      chk("R10 random valid", int'(rep_valid), 1);
      chk("R10 random kind", int'(rep_kind), (n == 0) ? 5 : code_of(first_t));
      chk("R10 random count", int'(rep_count), n);
      chk("R10 random page", int'(rep_page), (n >= 2) ? 1 : 0);
      chk("R9 random lane", int'(rep_lane_err), 0);
      chk("R11 random long", int'(rep_long_err), (low_run > RMAX) ? 1 : 0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule